// File: doc/BRIEF.md
# Look-Ahead-Carry Eight-Function ALU

This block is a purely combinational arithmetic/logic unit for 8-bit operands. A 3-bit function code selects one of eight results. The results are addition and subtraction through one shared adder, the three bitwise logic operations, a single-place shift of operand `b` in either direction, and a constant zero. Each bit position is a small slice that produces a local generate/propagate pair. The pairs are combined by a tree of two-input look-ahead nodes. Each node joins two half-width groups, so the carry into every bit is formed in logarithmic depth rather than by rippling.

Serial shift-in and shift-out pins let several units be chained into a wider shifter. Four status flags accompany every result: carry, zero, sign and two's-complement overflow. Carry and overflow carry meaning only for the two arithmetic codes.

Top module: `alu8_lca`

## Requirements
- R1: Code 0 (add): `f` equals the low 8 bits of a + b + ci, and `c_flag` equals bit 8 of that sum. A carry entering at `ci` must reach every bit position, for example a=0xFF, b=0x00, ci=1 gives f=0x00 with c_flag=1.
- R2: Code 1 (subtract) computes b − a as (~a) + b + ci, with `ci` acting as the borrow input. With b=0x9F, a=0x15, ci=1 the result is f=0x8A, c_flag=1, z_flag=0, s_flag=1, v_flag=0.
- R3: For codes 0 and 1, `v_flag` is 1 exactly when the carry into bit 7 differs from the carry out of bit 7. Equivalently, it is 1 when both adder operands share a sign and the result sign differs.
- R4: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of `a` and `b` respectively.
- R5: Code 5 gives f = {b[6:0], sl_in}: result bit 0 takes `sl_in` and bit i takes b[i−1].
- R6: Code 6 gives f = {sr_in, b[7:1]}: result bit 7 takes `sr_in` and bit i takes b[i+1].
- R7: Code 7 gives f = 0x00 regardless of all other inputs.
- R8: `sl_out` equals b[7] and `sr_out` equals b[0] for every function code.
- R9: For codes 2 through 7, `c_flag` and `v_flag` are both 0.
- R10: For every code, `z_flag` is 1 exactly when f is 0x00, and `s_flag` equals f[7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 8 | First operand; inverted into the adder for subtraction |
| b | input | 8 | Second operand; the only operand of the shifts |
| op_sel | input | 3 | Function code 0..7 |
| ci | input | 1 | Carry input for add, borrow input for subtract |
| sl_in | input | 1 | Serial bit entering bit 0 on a left shift |
| sr_in | input | 1 | Serial bit entering bit 7 on a right shift |
| f | output | 8 | Result |
| sl_out | output | 1 | Bit leaving on a left shift (b[7]) |
| sr_out | output | 1 | Bit leaving on a right shift (b[0]) |
| c_flag | output | 1 | Adder carry out (arithmetic codes only) |
| z_flag | output | 1 | Result is zero |
| s_flag | output | 1 | Result bit 7 |
| v_flag | output | 1 | Two's-complement overflow (arithmetic codes only) |

## Verification
The adder is driven with an all-propagate pattern (0xFF plus a carry in), which exposes any break in the look-ahead tree. It is also driven with pure-generate patterns and with sign-boundary sums such as 0x7F+0x01 and 0x80+0x80, which separate the overflow rule from the carry rule. Subtraction is tried with both borrow values and with the fixed 0x9F/0x15 case. The shifts use alternating bit patterns with each serial input at 0 and at 1, so that a swapped direction or a missing serial bit shows up. Several hundred pseudo-random operand sets cover every function code, and each is compared with an independent model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_ZERO = 3'd7
    } alu_op_e;

    // generate / propagate pair of a bit or a group
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_bit.sv
module alu_bit
    import alu8_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    ci,
    input  logic    lnb,
    input  logic    rnb,
    input  alu_op_e op,
    output logic    f,
    output gp_t     gp
);
    logic a_eff;

    // subtraction feeds the inverted first operand into the shared adder
    assign a_eff = (op == OP_SUB) ? ~a : a;
    assign gp.g  = a_eff & b;
    assign gp.p  = a_eff ^ b;

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: f = gp.p ^ ci;
            OP_AND:         f = a & b;
            OP_OR:          f = a | b;
            OP_XOR:         f = a ^ b;
            OP_SHL:         f = lnb;
            OP_SHR:         f = rnb;
            OP_ZERO:        f = 1'b0;
            default:        f = 1'b0;
        endcase
    end
endmodule

// File: rtl/lca_node.sv
module lca_node
    import alu8_pkg::*;
(
    input  gp_t  lo,
    input  gp_t  hi,
    input  logic ci,
    output logic c_mid,
    output gp_t  grp
);
    assign c_mid = lo.g | (lo.p & ci);
    assign grp   = gp_merge(hi, lo);
endmodule

// File: rtl/alu_tree.sv
module alu_tree
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] lnb,
    input  logic [W-1:0] rnb,
    input  alu_op_e      op,
    input  logic         ci,
    output logic [W-1:0] f,
    output logic [W-1:0] cvec,
    output gp_t          gp
);
    localparam int H = W / 2;

    generate
        if (W == 1) begin : g_leaf
            alu_bit u_bit (
                .a   (a[0]),
                .b   (b[0]),
                .ci  (ci),
                .lnb (lnb[0]),
                .rnb (rnb[0]),
                .op  (op),
                .f   (f[0]),
                .gp  (gp)
            );
            assign cvec[0] = ci;
        end else begin : g_split
            gp_t  gp_lo, gp_hi;
            logic c_hi;

            alu_tree #(.W(H)) u_lo (
                .a    (a[H-1:0]),
                .b    (b[H-1:0]),
                .lnb  (lnb[H-1:0]),
                .rnb  (rnb[H-1:0]),
                .op   (op),
                .ci   (ci),
                .f    (f[H-1:0]),
                .cvec (cvec[H-1:0]),
                .gp   (gp_lo)
            );
            alu_tree #(.W(W-H)) u_hi (
                .a    (a[W-1:H]),
                .b    (b[W-1:H]),
                .lnb  (lnb[W-1:H]),
                .rnb  (rnb[W-1:H]),
                .op   (op),
                .ci   (c_hi),
                .f    (f[W-1:H]),
                .cvec (cvec[W-1:H]),
                .gp   (gp_hi)
            );
            lca_node u_lca (
                .lo    (gp_lo),
                .hi    (gp_hi),
                .ci    (ci),
                .c_mid (c_hi),
                .grp   (gp)
            );
        end
    endgenerate
endmodule

// File: rtl/alu8_lca.sv
module alu8_lca
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op_sel,
    input  logic         ci,
    input  logic         sl_in,
    input  logic         sr_in,
    output logic [W-1:0] f,
    output logic         sl_out,
    output logic         sr_out,
    output logic         c_flag,
    output logic         z_flag,
    output logic         s_flag,
    output logic         v_flag
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    logic [W-1:0] lnb, rnb, cvec;
    gp_t          gp_all;
    logic         cout, arith;

    assign op    = alu_op_e'(op_sel);
    assign arith = is_arith(op);

    // one-place routing of b, with serial bits at the ends
    assign lnb    = {b[MSB-1:0], sl_in};
    assign rnb    = {sr_in, b[MSB:1]};
    assign sl_out = b[MSB];
    assign sr_out = b[0];

    alu_tree #(.W(W)) u_tree (
        .a    (a),
        .b    (b),
        .lnb  (lnb),
        .rnb  (rnb),
        .op   (op),
        .ci   (ci),
        .f    (f),
        .cvec (cvec),
        .gp   (gp_all)
    );

    assign cout   = gp_all.g | (gp_all.p & ci);
    assign c_flag = arith & cout;
    assign v_flag = arith & (cvec[MSB] ^ cout);
    assign z_flag = (f == '0);
    assign s_flag = f[MSB];

    // checks against independent arithmetic and routing
    logic [W:0]   ref_sum;
    logic [W-1:0] a_in;
    always_comb begin
        a_in    = (op == OP_SUB) ? ~a : a;
        ref_sum = {1'b0, a_in} + {1'b0, b} + {{W{1'b0}}, ci};
        if (op == OP_ADD)
            p_add_sum_r1: assert ({c_flag, f} == ref_sum);
        if (op == OP_SUB)
            p_sub_diff_r2: assert ({c_flag, f} == ref_sum);
        if (arith)
            p_overflow_r3: assert (v_flag == ((a_in[MSB] == b[MSB]) && (f[MSB] != b[MSB])));
        if (op == OP_AND)
            p_and_r4: assert (f == (a & b));
        if (op == OP_XOR)
            p_xor_r4: assert (f == (a ^ b));
        if (op == OP_SHL)
            p_shl_r5: assert (f == {b[MSB-1:0], sl_in});
        if (op == OP_SHR)
            p_shr_r6: assert (f == {sr_in, b[MSB:1]});
        if (op == OP_ZERO)
            p_zero_r7: assert (f == '0 && z_flag);
    end
endmodule

// File: tb/tb_alu8_lca.sv
`timescale 1ns/1ps
module tb_alu8_lca;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a = '0, b = '0;
    logic [2:0] op_sel = '0;
    logic       ci = 1'b0, sl_in = 1'b0, sr_in = 1'b0;
    logic [7:0] f;
    logic       sl_out, sr_out, c_flag, z_flag, s_flag, v_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected: {f, sl_out, sr_out, c, z, s, v}
    logic [13:0] exp_q[$];
    string       req_q[$];

    always #2.5 clk = ~clk;

    alu8_lca dut (
        .a(a), .b(b), .op_sel(op_sel), .ci(ci), .sl_in(sl_in), .sr_in(sr_in),
        .f(f), .sl_out(sl_out), .sr_out(sr_out),
        .c_flag(c_flag), .z_flag(z_flag), .s_flag(s_flag), .v_flag(v_flag)
    );

    function automatic logic [13:0] model(input logic [7:0] ia, ib, input logic [2:0] iop,
                                          input logic ici, isl, isr);
        logic [8:0] sum;
        logic [7:0] r, opa;
        logic c, v;
        c = 1'b0; v = 1'b0; r = 8'h00;
        case (iop)
            3'd0, 3'd1: begin
                opa = (iop == 3'd1) ? ~ia : ia;
                sum = {1'b0, opa} + {1'b0, ib} + {8'h00, ici};
                r = sum[7:0];
                c = sum[8];
                v = (opa[7] == ib[7]) && (r[7] != ib[7]);
            end
            3'd2: r = ia & ib;
            3'd3: r = ia | ib;
            3'd4: r = ia ^ ib;
            3'd5: r = {ib[6:0], isl};
            3'd6: r = {isr, ib[7:1]};
            default: r = 8'h00;
        endcase
        return {r, ib[7], ib[0], c, (r == 8'h00), r[7], v};
    endfunction

    task automatic apply(input logic [7:0] ia, ib, input logic [2:0] iop,
                         input logic ici, isl, isr, input string req);
        @(posedge clk);
        a = ia; b = ib; op_sel = iop; ci = ici; sl_in = isl; sr_in = isr;
        exp_q.push_back(model(ia, ib, iop, ici, isl, isr));
        req_q.push_back(req);
    endtask

    // monitor: compares at the falling edge after each drive
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [13:0] e, got;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            got = {f, sl_out, sr_out, c_flag, z_flag, s_flag, v_flag};
            checks++;
            if (got !== e) begin
                errors++;
                $display("FAIL %s: a=%h b=%h op=%0d ci=%b got {f,slo,sro,c,z,s,v}=%h/%b expected %h/%b",
                         r, a, b, op_sel, ci, got[13:6], got[5:0], e[13:6], e[5:0]);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-time inputs all zero: add of zeros gives zero result, Z set
        apply(8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, "R10 reset state");
        // R1 add, including full propagate and full generate
        apply(8'h12, 8'h34, 3'd0, 1'b0, 1'b0, 1'b0, "R1 add");
        apply(8'hFF, 8'h00, 3'd0, 1'b1, 1'b0, 1'b0, "R1 carry through all bits");
        apply(8'hFF, 8'hFF, 3'd0, 1'b1, 1'b0, 1'b0, "R1 all generate");
        apply(8'h0F, 8'h01, 3'd0, 1'b0, 1'b0, 1'b0, "R1 mid carry");
        // R2 subtract
        apply(8'h15, 8'h9F, 3'd1, 1'b1, 1'b0, 1'b0, "R2 b-a fixed case");
        apply(8'h15, 8'h9F, 3'd1, 1'b0, 1'b0, 1'b0, "R2 borrow in 0");
        apply(8'h9F, 8'h15, 3'd1, 1'b1, 1'b0, 1'b0, "R2 negative difference");
        // R3 overflow boundaries
        apply(8'h01, 8'h7F, 3'd0, 1'b0, 1'b0, 1'b0, "R3 positive overflow");
        apply(8'h80, 8'h80, 3'd0, 1'b0, 1'b0, 1'b0, "R3 negative overflow");
        apply(8'h01, 8'h80, 3'd1, 1'b1, 1'b0, 1'b0, "R3 subtract overflow");
        apply(8'hFF, 8'h01, 3'd0, 1'b0, 1'b0, 1'b0, "R3 carry without overflow");
        // R4 logic
        apply(8'hCC, 8'hAA, 3'd2, 1'b1, 1'b0, 1'b0, "R4 and");
        apply(8'hCC, 8'hAA, 3'd3, 1'b1, 1'b0, 1'b0, "R4 or");
        apply(8'hCC, 8'hAA, 3'd4, 1'b1, 1'b0, 1'b0, "R4 xor");
        // R5 / R6 shifts with both serial values
        apply(8'h00, 8'hA5, 3'd5, 1'b0, 1'b0, 1'b1, "R5 shl sl_in=0");
        apply(8'h00, 8'h5A, 3'd5, 1'b0, 1'b1, 1'b0, "R5 shl sl_in=1");
        apply(8'h00, 8'hA5, 3'd6, 1'b0, 1'b1, 1'b0, "R6 shr sr_in=0");
        apply(8'h00, 8'h5A, 3'd6, 1'b0, 1'b0, 1'b1, "R6 shr sr_in=1");
        // R7 zero
        apply(8'hFF, 8'hFF, 3'd7, 1'b1, 1'b1, 1'b1, "R7 zero");
        // R8 / R9 serial outputs and idle flags on non-arith codes
        apply(8'hFF, 8'h81, 3'd3, 1'b1, 1'b0, 1'b0, "R8 serial outs, R9 flags idle");
        apply(8'h80, 8'h80, 3'd2, 1'b1, 1'b0, 1'b0, "R9 no carry on and");
        // random sweep over all codes
        for (int i = 0; i < 400; i++) begin
            apply(8'($urandom), 8'($urandom), 3'(i % 8), 1'($urandom),
                  1'($urandom), 1'($urandom), "R10 random sweep");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule